// File: doc/BRIEF.md
# Interrupt Redirection Controller with Indirect Register Window

This block routes a set of external interrupt lines to interrupt messages. Each line has a 64-bit routing entry that sets how the line is sampled (active-high or active-low, edge or level) and what message it produces: vector, delivery mode, destination mode and destination. A line that is unmasked and active produces a message on a valid/ready output port, and the port holds the message until it is taken.

Software reaches every register through a two-word window. A write at byte offset 0x00 selects a register index. A read or write at byte offset 0x10 then reaches the selected 32-bit register. Indices 0 and 1 hold a fixed identifier and a version word. Each routing entry takes a pair of indices: the even one holds the low half and the odd one the high half.

Level-triggered lines carry an in-service flag. The flag is set when a message is sent for the line. While it is set the line cannot send again. It clears when an end-of-interrupt strobe arrives with the same vector.

Top module: `irq_route_ctl`

## Requirements
- R1: After reset the index register reads 0, every entry low word reads 0x00010000 (mask set, all else zero), every entry high word reads 0, and msg_valid is 0.
- R2: A write at bus_addr 0x00 loads the index from bus_wdata[7:0], and a read there returns the index in bits 7:0. A read or write at 0x10 reaches the selected register. Any other offset reads 0 and ignores writes.
- R3: Index 0 reads UNIT_ID in bits 31:24. Index 1 reads VERSION in bits 7:0 and NLINES-1 in bits 23:16. All other bits of both read 0, and writes to both are ignored.
- R4: Entry n is reached at index 0x10+2n (low word) and 0x11+2n (high word).
  - Low word fields: vector 7:0, delivery mode 10:8, destination mode 11, active-low 13, in-service 14 (read-only), level 15, mask 16.
  - High word: destination in bits 31:24.
  - All other bits read 0.
- R5: An index between 2 and 0x0F, or at or above 0x10+2*NLINES, reads 0, and a write to it changes no register.
- R6: Inputs pass through two synchronizer flops. An unmasked edge-mode line sends exactly one message per transition into its active level. msg_valid rises on the 4th rising clock edge after the input changes. With the active-low bit set, the falling transition is the active one.
- R7: An unmasked level-mode line that is active sends a message. msg_valid rises on the 3rd clock edge after the input changes, and the in-service bit is set at issue. No further message is sent until an end-of-interrupt strobe with an equal vector clears the bit. A strobe with another vector has no effect. If the line is still active after the clear, it sends again on the next edge.
- R8: A masked line sends nothing, and an edge that arrives while the line is masked is discarded. Writing the low word with only the mask cleared leaves the other fields unchanged. A level line that is still active then sends.
- R9: When several lines request together, the lowest-numbered line is sent first.
- R10: While msg_valid is 1 and msg_ready is 0, the message fields hold steady. One message leaves per cycle in which msg_valid and msg_ready are both 1.
- R11: The message carries the vector, delivery mode, destination mode and destination of the sending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset: 0x00 index, 0x10 data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr and the index |
| irq_in | input | NLINES | Asynchronous interrupt input lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt strobe |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode |
| msg_dstm | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |

## Verification
A corrupted routing field appears straight away on a data-window readback, and again in the next message from that line. A stuck pending or in-service flag shows up within a few cycles as a missing, duplicated or early message. Every edge-mode and level-mode case therefore checks the exact arrival cycle of msg_valid, and confirms silence for a window after the message is taken. A fault in the selection order shows as out-of-order vectors when several lines fire together.

// File: rtl/irq_route_ctl.sv
module irq_route_ctl #(
  parameter int NLINES = 24,
  parameter logic [7:0] UNIT_ID = 8'h0A,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] irq_in,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dlv,
  output logic              msg_dstm,
  output logic [7:0]        msg_dest
);

  localparam int LW = $clog2(NLINES);
  localparam int IDX_END = 16 + 2 * NLINES;

  logic [7:0] idx_q;
  logic [7:0] vec_q [NLINES];
  logic [2:0] dlv_q [NLINES];
  logic [7:0] dst_q [NLINES];
  logic [NLINES-1:0] dstm_q, pol_q, trig_q, mask_q, irr_q, pend_q;
  logic [NLINES-1:0] s1_q, s2_q, s3_q;

  logic [NLINES-1:0] act_now, act_prev, edge_hit, req;
  logic [LW-1:0] sel, ent_n;
  logic [7:0] off;
  logic take, ent_hit, win_wr;

  assign act_now  = s2_q ^ pol_q;
  assign act_prev = s3_q ^ pol_q;
  assign edge_hit = act_now & ~act_prev;
  assign req = ~mask_q & ((trig_q & act_now & ~irr_q) | (~trig_q & pend_q));
  assign take = (|req) && !msg_valid;

  assign off = idx_q - 8'd16;
  assign ent_n = off[LW:1];
  assign ent_hit = (idx_q >= 8'd16) && (32'(idx_q) < IDX_END);
  assign win_wr = bus_we && (bus_addr == 5'h10);

  logic unused_bits;
  assign unused_bits = ^{off[7:LW+1], off[0], bus_wdata[23:17], bus_wdata[14], bus_wdata[12]};

  always_comb begin
    sel = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (req[i]) sel = LW'(i);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 5'h00)
      bus_rdata = {24'b0, idx_q};
    else if (bus_addr == 5'h10) begin
      if (idx_q == 8'd0)
        bus_rdata = {UNIT_ID, 24'b0};
      else if (idx_q == 8'd1)
        bus_rdata = {8'b0, 8'(NLINES - 1), 8'b0, VERSION};
      else if (ent_hit) begin
        if (idx_q[0])
          bus_rdata = {dst_q[ent_n], 24'b0};
        else
          bus_rdata = {15'b0, mask_q[ent_n], trig_q[ent_n], irr_q[ent_n], pol_q[ent_n],
                       1'b0, dstm_q[ent_n], dlv_q[ent_n], vec_q[ent_n]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
      dstm_q <= '0;
      pol_q <= '0;
      trig_q <= '0;
      mask_q <= '1;
      irr_q <= '0;
      pend_q <= '0;
      for (int i = 0; i < NLINES; i++) begin
        vec_q[i] <= '0;
        dlv_q[i] <= '0;
        dst_q[i] <= '0;
      end
      msg_valid <= 1'b0;
      msg_vector <= '0;
      msg_dlv <= '0;
      msg_dstm <= 1'b0;
      msg_dest <= '0;
    end else begin
      s1_q <= irq_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (bus_we && bus_addr == 5'h00)
        idx_q <= bus_wdata[7:0];

      for (int i = 0; i < NLINES; i++) begin
        pend_q[i] <= ~mask_q[i] & ~trig_q[i] &
                     ((pend_q[i] & ~(take && sel == LW'(i))) | edge_hit[i]);
        if (take && sel == LW'(i) && trig_q[i])
          irr_q[i] <= 1'b1;
        else if (eoi_valid && eoi_vector == vec_q[i])
          irr_q[i] <= 1'b0;
      end

      if (win_wr && ent_hit) begin
        if (idx_q[0])
          dst_q[ent_n] <= bus_wdata[31:24];
        else begin
          vec_q[ent_n]  <= bus_wdata[7:0];
          dlv_q[ent_n]  <= bus_wdata[10:8];
          dstm_q[ent_n] <= bus_wdata[11];
          pol_q[ent_n]  <= bus_wdata[13];
          trig_q[ent_n] <= bus_wdata[15];
          mask_q[ent_n] <= bus_wdata[16];
          if (!bus_wdata[15])
            irr_q[ent_n] <= 1'b0;
        end
      end

      if (msg_valid && msg_ready)
        msg_valid <= 1'b0;
      else if (take) begin
        msg_valid <= 1'b1;
        msg_vector <= vec_q[sel];
        msg_dlv <= dlv_q[sel];
        msg_dstm <= dstm_q[sel];
        msg_dest <= dst_q[sel];
      end
    end
  end

endmodule

module irq_route_ctl_chk #(
  parameter int NLINES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_dlv,
  input logic              msg_dstm,
  input logic [7:0]        msg_dest,
  input logic [NLINES-1:0] irr,
  input logic [NLINES-1:0] lvl
);

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable({msg_vector, msg_dlv, msg_dstm, msg_dest}));

  // R7
  irr_level_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~lvl) == '0);

  // R7
  irr_set_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irr)) != '0 |-> msg_valid && $countones(irr & ~$past(irr)) == 1);

  // R2
  addr_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 5'h00 && bus_addr != 5'h10) |-> bus_rdata == '0);

endmodule

bind irq_route_ctl irq_route_ctl_chk #(.NLINES(NLINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
  .msg_dlv(msg_dlv), .msg_dstm(msg_dstm), .msg_dest(msg_dest),
  .irr(irr_q), .lvl(trig_q)
);

// File: tb/irq_route_ctl_tb.sv
module irq_route_ctl_tb_top;
  localparam int N = 24;
  localparam logic [7:0] UID = 8'h0A;
  localparam logic [7:0] VER = 8'h11;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = 0;
  logic msg_valid, msg_ready = 0;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_dlv;
  logic msg_dstm;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_route_ctl #(.NLINES(N), .UNIT_ID(UID), .VERSION(VER)) dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [31:0] d);
    wr(5'h00, {24'b0, i}); wr(5'h10, d);
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [31:0] d);
    wr(5'h00, {24'b0, i}); rd(5'h10, d);
  endtask

  task automatic wait_msg(output int n);
    n = 0;
    while (!msg_valid && n < 20) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  task automatic quiet(input string tag, input int c);
    int seen = 0;
    for (int k = 0; k < c; k++) begin @(negedge clk); if (msg_valid) seen = 1; end
    chk(tag, seen, 0);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1; eoi_vector = v;
    @(negedge clk); eoi_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 msg_valid", msg_valid, 0);
    rd(5'h00, d); chk("R1 index", d, 0);
    for (int i = 0; i < N; i++) begin
      rd_reg(8'(16 + 2*i), d); chk("R1 low word", d, 32'h0001_0000);
      rd_reg(8'(17 + 2*i), d); chk("R1 high word", d, 0);
    end

    // R2 R3 R4 R5 sweep of every index with all-ones writes
    for (int i = 0; i < 80; i++) begin
      wr_reg(8'(i), 32'hFFFF_FFFF);
      rd(5'h00, d); chk("R2 index readback", d, i);
      rd(5'h10, d);
      if (i == 0) exp = {UID, 24'b0};
      else if (i == 1) exp = {8'b0, 8'(N-1), 8'b0, VER};
      else if (i >= 16 && i < 16 + 2*N) exp = (i % 2 == 0) ? 32'h0001_AFFF : 32'hFF00_0000;
      else exp = 0;
      if (i < 2) chk("R3 id/version", d, exp);
      else if (i < 16 + 2*N && i >= 16) chk("R4 entry fields", d, exp);
      else chk("R5 absent index", d, exp);
      if (i >= 16 && i < 16 + 2*N) wr(5'h10, (i % 2 == 0) ? 32'h0001_0000 : 32'h0);
    end
    wr(5'h04, 32'h55); rd(5'h00, d); chk("R2 stray offset write", d[7:0], 8'd79);
    rd(5'h08, d); chk("R2 stray offset read", d, 0);

    // R6 R11 edge mode on every line
    for (int i = 0; i < N; i++) begin
      logic [31:0] lo;
      lo = (32'h20 + i) | (32'(i % 8) << 8) | (32'(i & 1) << 11);
      wr_reg(8'(17 + 2*i), 32'(i * 3) << 24);
      wr_reg(8'(16 + 2*i), lo);
      rd(5'h10, d); chk("R4 low readback", d, lo);
      @(negedge clk); irq_in[i] = 1;
      wait_msg(n);
      chk("R6 edge latency", n, 4);
      chk("R11 vector", msg_vector, 32'h20 + i);
      chk("R11 delivery", msg_dlv, i % 8);
      chk("R11 dest mode", msg_dstm, i & 1);
      chk("R11 dest", msg_dest, (i * 3) % 256);
      accept();
      chk("R10 valid drops after accept", msg_valid, 0);
      quiet("R6 single message per edge", 8);
      irq_in[i] = 0;
      quiet("R6 inactive edge silent", 8);
      wr_reg(8'(16 + 2*i), 32'h0001_0000);
    end

    // R6 active-low edge on line 5
    @(negedge clk); irq_in[5] = 1;
    repeat (4) @(negedge clk);
    wr_reg(8'(16 + 10), 32'h0000_2055);
    quiet("R6 active-low idle", 8);
    @(negedge clk); irq_in[5] = 0;
    wait_msg(n); chk("R6 falling edge latency", n, 4);
    chk("R6 falling edge vector", msg_vector, 8'h55);
    accept();
    irq_in[5] = 1;
    quiet("R6 rising edge ignored when active-low", 10);
    wr_reg(8'(16 + 10), 32'h0001_0000);
    irq_in[5] = 0;

    // R7 level mode with in-service flag on line 7
    wr_reg(8'(16 + 14), 32'h0000_8047);
    @(negedge clk); irq_in[7] = 1;
    wait_msg(n); chk("R7 level latency", n, 3);
    chk("R7 vector", msg_vector, 8'h47);
    accept();
    rd_reg(8'(16 + 14), d); chk("R7 in-service set", d, 32'h0000_C047);
    quiet("R7 blocked while in service", 10);
    eoi(8'h48);
    quiet("R7 other vector eoi ignored", 10);
    rd(5'h10, d); chk("R7 in-service kept", d, 32'h0000_C047);
    wr(5'h10, 32'h0000_8047);
    rd(5'h10, d); chk("R4 in-service read-only", d, 32'h0000_C047);
    eoi(8'h47);
    wait_msg(n); chk("R7 reissue after eoi", n, 1);
    accept();
    @(negedge clk); irq_in[7] = 0;
    eoi(8'h47);
    quiet("R7 no message after line drops", 10);
    rd_reg(8'(16 + 14), d); chk("R7 in-service cleared", d, 32'h0000_8047);
    wr(5'h10, 32'h0001_0000);

    // R8 masking
    wr_reg(8'(16 + 6), 32'h0001_0033);
    @(negedge clk); irq_in[3] = 1;
    quiet("R8 masked edge silent", 10);
    rd(5'h10, d);
    wr(5'h10, d & ~32'h0001_0000);
    rd(5'h10, d); chk("R8 unmask keeps fields", d, 32'h0000_0033);
    quiet("R8 edge during mask discarded", 10);
    irq_in[3] = 0;
    wr(5'h10, 32'h0001_0000);
    wr_reg(8'(16 + 18), 32'h0001_8099);
    @(negedge clk); irq_in[9] = 1;
    quiet("R8 masked level silent", 10);
    wr(5'h10, 32'h0000_8099);
    wait_msg(n); chk("R8 unmasked level sends", msg_vector, 8'h99);
    accept();
    irq_in[9] = 0;
    eoi(8'h99);
    wr_reg(8'(16 + 18), 32'h0001_0000);

    // R9 R10 priority and hold
    wr_reg(8'(16 + 30), 32'h0000_80F0);
    wr_reg(8'(16 + 12), 32'h0000_80B0);
    wr_reg(8'(16 + 4), 32'h0000_80A0);
    @(negedge clk); irq_in[2] = 1; irq_in[6] = 1; irq_in[15] = 1;
    wait_msg(n); chk("R9 first is line 2", msg_vector, 8'hA0);
    repeat (5) @(negedge clk);
    chk("R10 held valid", msg_valid, 1);
    chk("R10 held vector", msg_vector, 8'hA0);
    accept();
    wait_msg(n); chk("R9 second is line 6", msg_vector, 8'hB0);
    chk("R10 next message one cycle after accept", n, 1);
    accept();
    wait_msg(n); chk("R9 third is line 15", msg_vector, 8'hF0);
    accept();
    quiet("R10 one message per handshake", 10);
    irq_in = '0;
    eoi(8'hA0); eoi(8'hB0); eoi(8'hF0);
    quiet("R7 all cleared no repeat", 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule